// File: doc/BRIEF.md
# Serial Long-Division CRC Engine

This block computes a cyclic redundancy check one bit per clock. A register of `WIDTH` cells, one cell shorter than the generator polynomial, performs mod-2 long division. XOR stands for both addition and subtraction, and there are no carries. Each accepted bit enters the low cell. When the bit leaving the top cell is 1, the generator is subtracted.

The same hardware serves both directions. To generate a check sequence, the user clears the register and shifts in the message with its most significant bit first. The user then shifts in `WIDTH` zero bits. The register then holds the check sequence to append to the message. To check a frame, the user clears the register and shifts in the whole received frame. If the frame is intact, the register ends at zero and the zero-residue flag is high. Any nonzero residue means an error was detected.

The generator is the parameter `POLY`, given without its implied leading term. Bit i of `POLY` is the coefficient of x^i.

Top module: `crc_serial_engine`

## Requirements
- R1: While `rst` is high at a rising edge, the register is loaded with zero, so after that edge `crc_q` is 0 and `zero_res` is 1.
- R2: A high `clr` zeroes the register at the next edge. It wins over `bit_en` when both are high in the same cycle.
- R3: With `clr` and `bit_en` both low, `crc_q` keeps its value whatever `bit_in` does.
- R4: With `bit_en` high and `clr` low, the register is loaded with `{crc_q[WIDTH-2:0], bit_in}`, XORed with `POLY` when `crc_q[WIDTH-1]` was 1. After a clear, the register therefore equals the bits shifted so far, taken as a polynomial with the first bit as the highest power, reduced modulo the generator.
- R5: Shifting in a message (most significant bit first) followed by `WIDTH` zeros leaves the check sequence in `crc_q`. For generator 110101 and message 1010001101 the sequence is 01110.
- R6: Shifting in a message followed by its check sequence leaves `crc_q` at 0 and `zero_res` at 1.
- R7: With generator x^4+x^3+1 (`WIDTH`=4, `POLY`=4'b1001), flipping any single bit of a 15-bit codeword leaves a nonzero residue.
- R8: Any error burst shorter than `WIDTH` bits in a codeword leaves a nonzero residue.
- R9: `zero_res` is high exactly when `crc_q` is all zeros, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Start-of-frame clear strobe |
| bit_en | input | 1 | Accepts `bit_in` this cycle |
| bit_in | input | 1 | Serial data bit |
| crc_q | output | WIDTH | Register contents (check sequence or residue) |
| zero_res | output | 1 | High when the register is all zeros |

## Verification
The clear strobe and a bit shift can fall in the same cycle. The bench provokes this by first loading a nonzero value and then raising `clr` together with `bit_en` and a 1 on `bit_in`. The bench judges the result by requiring an all-zero register with the flag high one edge later. A shifted bit would instead have left the value 1 or more.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_ZERO  = 2'd2
  } crc_op_e;
endpackage

// File: rtl/crc_op_decode.sv
module crc_op_decode
  import crc_serial_pkg::*;
(
  input  logic    rst,
  input  logic    clr,
  input  logic    bit_en,
  output crc_op_e op
);
  // reset and clear both zero the register; clear outranks a shift
  always_comb begin
    if (rst || clr)   op = OP_ZERO;
    else if (bit_en)  op = OP_SHIFT;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/crc_step.sv
module crc_step #(
  parameter int              WIDTH = 5,
  parameter logic [WIDTH-1:0] POLY = 5'b10101
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             din,
  output logic [WIDTH-1:0] nxt
);
  logic top;
  assign top = cur[WIDTH-1];

  // cell 0 takes the new bit; a tap adds the divisor where its coefficient is 1
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic from_below;
    if (i == 0) begin : g_low
      assign from_below = din;
    end else begin : g_up
      assign from_below = cur[i-1];
    end
    if (POLY[i]) begin : g_tap
      assign nxt[i] = from_below ^ top;
    end else begin : g_plain
      assign nxt[i] = from_below;
    end
  end
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg
  import crc_serial_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  crc_op_e          op,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    case (op)
      OP_ZERO:  q <= '0;
      OP_SHIFT: q <= nxt;
      default:  q <= q;
    endcase
  end
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_serial_pkg::*;
#(
  parameter int              WIDTH = 5,
  parameter logic [WIDTH-1:0] POLY = 5'b10101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] crc_q,
  output logic             zero_res
);
  crc_op_e          op;
  logic [WIDTH-1:0] nxt;

  crc_op_decode u_dec (
    .rst    (rst),
    .clr    (clr),
    .bit_en (bit_en),
    .op     (op)
  );

  crc_step #(.WIDTH(WIDTH), .POLY(POLY)) u_step (
    .cur (crc_q),
    .din (bit_in),
    .nxt (nxt)
  );

  crc_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk (clk),
    .op  (op),
    .nxt (nxt),
    .q   (crc_q)
  );

  assign zero_res = ~|crc_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_q == '0)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr && !bit_en) |=> $stable(crc_q)); // R3

  AST_PLAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !clr && !crc_q[WIDTH-1]) |=>
      (crc_q == {$past(crc_q[WIDTH-2:0]), $past(bit_in)})); // R4

  AST_FLAG_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> zero_res); // R9
endmodule

// File: tb/crc_serial_engine_test.sv
`timescale 1ns/1ps
module crc_serial_engine_test;
  localparam int WA = 5;
  localparam int WB = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic a_clr = 0, a_en = 0, a_din = 0;
  logic b_clr = 0, b_en = 0, b_din = 0;
  logic [WA-1:0] a_q;
  logic [WB-1:0] b_q;
  logic a_z, b_z;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  crc_serial_engine #(.WIDTH(WA), .POLY(5'b10101)) uut (
    .clk(clk), .rst(rst), .clr(a_clr), .bit_en(a_en), .bit_in(a_din),
    .crc_q(a_q), .zero_res(a_z));

  crc_serial_engine #(.WIDTH(WB), .POLY(4'b1001)) uut_b (
    .clk(clk), .rst(rst), .clr(b_clr), .bit_en(b_en), .bit_in(b_din),
    .crc_q(b_q), .zero_res(b_z));

  // mod-2 long division of a len-bit value by a full generator of degree w
  function automatic longint poly_mod(longint v, int len, longint pfull, int w);
    for (int i = len - 1; i >= w; i--)
      if (v[i]) v = v ^ (pfull << (i - w));
    return v & ((longint'(1) << w) - 1);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic a_clear();
    @(negedge clk) a_clr = 1;
    @(negedge clk) a_clr = 0;
  endtask
  task automatic a_shift(logic b);
    @(negedge clk) begin a_en = 1; a_din = b; end
    @(negedge clk) a_en = 0;
  endtask
  task automatic a_frame(longint v, int len);
    a_clear();
    for (int i = len - 1; i >= 0; i--) a_shift(v[i]);
  endtask
  task automatic b_clear();
    @(negedge clk) b_clr = 1;
    @(negedge clk) b_clr = 0;
  endtask
  task automatic b_shift(logic b);
    @(negedge clk) begin b_en = 1; b_din = b; end
    @(negedge clk) b_en = 0;
  endtask
  task automatic b_frame(longint v, int len);
    b_clear();
    for (int i = len - 1; i >= 0; i--) b_shift(v[i]);
  endtask

  localparam longint PA = 64'h35; // 110101
  localparam longint PB = 64'h19; // x^4+x^3+1

  initial begin
    longint cw, fcs, pat;
    repeat (3) @(negedge clk);
    chk("R1 reg", a_q, 0);
    chk("R1 flag", a_z, 1);
    chk("R1 reg b", b_q, 0);
    rst = 0;

    // R5 worked example and R4 per-step prefix residue
    a_clear();
    cw = 64'b1010001101;
    for (int i = 9; i >= 0; i--) begin
      a_shift(cw[i]);
      chk("R4 prefix", a_q, poly_mod(cw >> i, 10 - i, PA, WA));
    end
    for (int i = 0; i < WA; i++) a_shift(1'b0);
    chk("R5 example fcs", a_q, 5'b01110);
    a_frame(64'b101000110101110, 15);
    chk("R6 example residue", a_q, 0);
    chk("R6 example flag", a_z, 1);

    // R3: idle with toggling data keeps the value
    a_clear(); a_shift(1); a_shift(1); a_shift(0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) a_din = i[0];
      chk("R3 hold", a_q, 5'b00110);
    end
    chk("R9 nonzero flag", a_z, 0);

    // R2: clear together with a shift of 1
    @(negedge clk) begin a_clr = 1; a_en = 1; a_din = 1; end
    @(negedge clk) begin a_clr = 0; a_en = 0; end
    chk("R2 clear wins", a_q, 0);
    chk("R2 flag", a_z, 1);

    // R5/R6/R9 exhaustive over 10-bit messages
    for (int m = 0; m < 1024; m++) begin
      a_frame(longint'(m) << WA, 10 + WA);
      fcs = poly_mod(longint'(m) << WA, 10 + WA, PA, WA);
      chk("R5 sweep fcs", a_q, fcs);
      chk("R9 sweep flag", a_z, (fcs == 0));
      a_frame((longint'(m) << WA) | fcs, 10 + WA);
      chk("R6 sweep residue", a_q, 0);
      chk("R6 sweep flag", a_z, 1);
    end

    // R8 bursts shorter than WIDTH on a few codewords
    for (int m = 5; m < 1024; m += 400) begin
      cw = (longint'(m) << WA) | poly_mod(longint'(m) << WA, 15, PA, WA);
      for (int len = 1; len < WA; len++)
        for (int mid = 0; mid < (len > 2 ? (1 << (len - 2)) : 1); mid++) begin
          pat = (len == 1) ? 1 : ((longint'(1) << (len - 1)) | (longint'(mid) << 1) | 1);
          for (int pos = 0; pos + len <= 15; pos++) begin
            a_frame(cw ^ (pat << pos), 15);
            checks++;
            if (a_q == 0) begin
              fails++;
              $display("FAIL R8 burst len %0d pos %0d: actual %0h expected nonzero", len, pos, a_q);
            end
          end
        end
    end

    // R7 single-bit flips with generator x^4+x^3+1
    for (int m = 0; m < 2048; m += 32) begin
      cw = (longint'(m) << WB) | poly_mod(longint'(m) << WB, 15, PB, WB);
      b_frame(cw, 15);
      chk("R7 clean residue", b_q, 0);
      for (int f = 0; f < 15; f++) begin
        b_frame(cw ^ (longint'(1) << f), 15);
        checks++;
        if (b_q == 0 || b_z !== 1'b0) begin
          fails++;
          $display("FAIL R7 flip bit %0d: actual %0h expected nonzero", f, b_q);
        end
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule